// File: doc/BRIEF.md
# Oversampling Accumulate-Decimate Filter

This block turns a burst of 12-bit converter results from one chosen input channel into a single filtered value. A start pulse clears the running sum and opens a burst. Each valid sample whose channel tag equals the selected channel is then added, until the programmed ratio of 4, 16, 64 or 256 samples has been taken. The finished sum is reduced in one of two ways. In oversampling mode the output gains one bit of resolution for every factor of four in the ratio. In averaging mode the output is a plain mean, optionally carrying four fractional bits.

When the burst ends, the 16-bit result is registered and a sticky ready flag rises. If interrupts are enabled, a one-cycle interrupt pulse fires at the same time. The ready flag stays set until software acknowledges the read or a new start arrives. The ratio, mode, output width and channel are captured when the start pulse is taken, so reprogramming them during a burst affects only the next one.

Top module: `ovs_filter`

## Requirements
- R1: While `cfg_enable` is 0, start pulses and samples are ignored: no ready flag rises and no interrupt is produced.
- R2: A start pulse with the block enabled clears the sum and the ready flag (low from the next cycle) and opens a burst; a sample presented in the same cycle as the start is not counted.
- R3: `cfg_ratio_sel` codes 0, 1, 2, 3 select 4, 16, 64, 256 samples (exponent x = 1..4); codes 4 to 7 select 4 samples. The ready flag stays low until the last of those samples has been accepted.
- R4: Only samples with `smp_valid` = 1 and `smp_chan` equal to the captured channel are accumulated; other samples are skipped without ending the burst.
- R5: In oversampling mode (`cfg_avg` = 0), the result is the sum shifted right by x, right-aligned in 16 bits (12+x significant bits).
- R6: In averaging mode with `cfg_wide16` = 0, the result is the sum shifted right by 2x, a 12-bit mean.
- R7: In averaging mode with `cfg_wide16` = 1, the result is (sum × 16) shifted right by 2x, a mean with 4 fractional bits.
- R8: The result and ready flag are registered in the clock edge that accepts the last sample. They then hold, with the result unchanged, until `rd_ack` clears the ready flag or a new start is taken. After reset, the result, ready flag and interrupt are all 0.
- R9: `res_irq` is a one-cycle pulse that coincides with the rise of the ready flag, and it occurs only if `cfg_irq_en` is 1 in that completing cycle.
- R10: Ratio, mode, output width and channel are captured at the start pulse; changing them during a burst does not alter that burst's count or result.
- R11: Clearing `cfg_enable` during a burst abandons it; samples after re-enabling do not complete it without a new start.
- R12: The 20-bit sum holds 256 full-scale samples exactly (256 × 4095 in oversampling mode gives 65520).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Filter enable |
| cfg_avg | input | 1 | 0 = oversampling, 1 = averaging |
| cfg_ratio_sel | input | 3 | Ratio select code |
| cfg_chan | input | 5 | Channel to filter |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_wide16 | input | 1 | Averaging output with 4 fractional bits |
| trig | input | 1 | Start pulse for a burst |
| smp_valid | input | 1 | Sample valid |
| smp_chan | input | 5 | Channel tag of the sample |
| smp_data | input | 12 | Sample value |
| rd_ack | input | 1 | Result read; clears the ready flag |
| res_data | output | 16 | Filtered result |
| res_ready | output | 1 | Sticky result-ready flag |
| res_irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check the ready-flag protocol on every cycle: the flag clears after a start, it drops after an acknowledge, the result holds while the flag is set, and the interrupt appears only with a rising flag, only with its enable set, and never while the block is disabled. The arithmetic cannot be seen from the ports cycle by cycle. The scenarios cover it instead: the per-mode scaling, the ratio decoding including the unused codes, channel filtering, configuration capture, full-scale sums and aborted bursts. The bench predicts each result and compares it when the flag rises.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

  typedef enum logic {
    MODE_OVS = 1'b0,
    MODE_AVG = 1'b1
  } ovs_mode_e;

  // Extra-bit exponent for a ratio select code; unused codes fall back to 4x.
  function automatic int unsigned ratio_exp(input int unsigned sel);
    return (sel < 4) ? sel + 1 : 1;
  endfunction

endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl #(
  parameter int CNT_W = 8,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             hit,
  input  logic [EXP_W-1:0] exp_lat,
  output logic             busy,
  output logic             accept,
  output logic             last
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'((1 << {exp_lat, 1'b0}) - 1);
  assign accept = busy && en && hit && !start;
  assign last   = accept && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (accept) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
  parameter int IN_W  = 12,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] sum_next
);

  logic [ACC_W-1:0] acc;

  assign sum_next = acc + {{(ACC_W-IN_W){1'b0}}, din};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (add) begin
      acc <= sum_next;
    end
  end

endmodule

// File: rtl/ovs_shape.sv
module ovs_shape #(
  parameter int ACC_W = 20,
  parameter int OUT_W = 16,
  parameter int IN_W  = 12,
  parameter int EXP_W = 3
) (
  input  logic [ACC_W-1:0] sum,
  input  logic [EXP_W-1:0] exp_lat,
  input  ovs_pkg::ovs_mode_e mode,
  input  logic             wide,
  output logic [OUT_W-1:0] out
);

  localparam int FRAC_W = OUT_W - IN_W;
  localparam int EXT_W  = ACC_W + FRAC_W;

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] sel_val;

  assign ext = {sum, {FRAC_W{1'b0}}};

  always_comb begin
    if (mode == ovs_pkg::MODE_OVS) begin
      sel_val = {{FRAC_W{1'b0}}, sum} >> exp_lat;
    end else if (wide) begin
      sel_val = ext >> {exp_lat, 1'b0};
    end else begin
      sel_val = {{FRAC_W{1'b0}}, sum} >> {exp_lat, 1'b0};
    end
  end

  assign out = OUT_W'(sel_val);

endmodule

// File: rtl/ovs_filter.sv
module ovs_filter #(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 16,
  parameter int ACC_W   = 20,
  parameter int CH_W    = 5,
  parameter int SEL_W   = 3,
  parameter int MAX_EXP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_avg,
  input  logic [SEL_W-1:0] cfg_ratio_sel,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_irq_en,
  input  logic             cfg_wide16,
  input  logic             trig,
  input  logic             smp_valid,
  input  logic [CH_W-1:0]  smp_chan,
  input  logic [IN_W-1:0]  smp_data,
  input  logic             rd_ack,
  output logic [OUT_W-1:0] res_data,
  output logic             res_ready,
  output logic             res_irq
);

  localparam int CNT_W = 2 * MAX_EXP;
  localparam int EXP_W = $clog2(MAX_EXP + 1);

  logic               take_start;
  logic [EXP_W-1:0]   lat_exp;
  ovs_pkg::ovs_mode_e lat_mode;
  logic               lat_wide;
  logic [CH_W-1:0]    lat_chan;
  logic               busy, accept, last;
  logic [ACC_W-1:0]   sum_next;
  logic [OUT_W-1:0]   shaped;

  assign take_start = trig && cfg_enable;

  // Burst configuration captured at the start pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_exp  <= EXP_W'(1);
      lat_mode <= ovs_pkg::MODE_OVS;
      lat_wide <= 1'b0;
      lat_chan <= '0;
    end else if (take_start) begin
      lat_exp  <= EXP_W'(ovs_pkg::ratio_exp(32'(cfg_ratio_sel)));
      lat_mode <= cfg_avg ? ovs_pkg::MODE_AVG : ovs_pkg::MODE_OVS;
      lat_wide <= cfg_wide16;
      lat_chan <= cfg_chan;
    end
  end

  ovs_ctrl #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg_enable),
    .start   (take_start),
    .hit     (smp_valid && (smp_chan == lat_chan)),
    .exp_lat (lat_exp),
    .busy    (busy),
    .accept  (accept),
    .last    (last)
  );

  ovs_accum #(.IN_W(IN_W), .ACC_W(ACC_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .clr      (take_start),
    .add      (accept),
    .din      (smp_data),
    .sum_next (sum_next)
  );

  ovs_shape #(.ACC_W(ACC_W), .OUT_W(OUT_W), .IN_W(IN_W), .EXP_W(EXP_W)) u_shape (
    .sum     (sum_next),
    .exp_lat (lat_exp),
    .mode    (lat_mode),
    .wide    (lat_wide),
    .out     (shaped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_ready <= 1'b0;
      res_irq   <= 1'b0;
    end else begin
      res_irq <= 1'b0;
      if (last) begin
        res_data  <= shaped;
        res_ready <= 1'b1;
        res_irq   <= cfg_irq_en;
      end else if (take_start || rd_ack) begin
        res_ready <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ovs_filter_chk.sv
module ovs_filter_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic             cfg_irq_en,
  input logic             trig,
  input logic             rd_ack,
  input logic [OUT_W-1:0] res_data,
  input logic             res_ready,
  input logic             res_irq
);

  p_start_clears_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (trig && cfg_enable) |=> !res_ready);

  p_ack_clears_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (res_ready && rd_ack) |=> !res_ready);

  p_result_holds_r8: assert property (@(posedge clk) disable iff (rst)
    res_ready |=> $stable(res_data));

  p_irq_with_ready_r9: assert property (@(posedge clk) disable iff (rst)
    res_irq |-> $rose(res_ready));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    res_irq |-> $past(cfg_irq_en));

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !res_irq);

endmodule

bind ovs_filter ovs_filter_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_enable (cfg_enable),
  .cfg_irq_en (cfg_irq_en),
  .trig       (trig),
  .rd_ack     (rd_ack),
  .res_data   (res_data),
  .res_ready  (res_ready),
  .res_irq    (res_irq)
);

// File: tb/ovs_filter_bench.sv
module ovs_filter_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0, cfg_avg = 1'b0, cfg_irq_en = 1'b0, cfg_wide16 = 1'b0;
  logic [2:0]  cfg_ratio_sel = '0;
  logic [4:0]  cfg_chan = '0;
  logic        trig = 1'b0, smp_valid = 1'b0, rd_ack = 1'b0;
  logic [4:0]  smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic [15:0] res_data;
  logic        res_ready, res_irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [16:0] exp_q[$];
  logic        prev_rdy = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ovs_filter u_ovs_filter (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_avg(cfg_avg),
    .cfg_ratio_sel(cfg_ratio_sel), .cfg_chan(cfg_chan), .cfg_irq_en(cfg_irq_en),
    .cfg_wide16(cfg_wide16), .trig(trig), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .rd_ack(rd_ack), .res_data(res_data), .res_ready(res_ready),
    .res_irq(res_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model(input int sel, input bit avg, input bit w16, input int sum);
    int x = (sel < 4) ? sel + 1 : 1;
    if (!avg) return 16'(sum >> x);
    if (w16) return 16'((sum * 16) >> (2 * x));
    return 16'(sum >> (2 * x));
  endfunction

  // Monitor: pops the scoreboard when the ready flag rises
  always @(negedge clk) begin
    if (!rst) begin
      if (res_ready && !prev_rdy) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", int'(res_data), -1);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          check(res_data == e[15:0], "R5/R6/R7 result value", int'(res_data), int'(e[15:0]));
          check(res_irq == e[16], "R9 irq with ready", int'(res_irq), int'(e[16]));
        end
      end else if (res_irq) begin
        check(1'b0, "R9 irq without ready rise", 1, 0);
      end
      prev_rdy = res_ready;
    end
  end

  task automatic run_burst(input int sel, input bit avg, input bit w16, input int ch,
                           input bit ie, input int seed, input bit full,
                           input bit foreign, input bit scramble, input bit trig_smp);
    int n = 1 << (2 * ((sel < 4) ? sel + 1 : 1));
    int sum = 0;
    @(negedge clk);
    cfg_enable = 1'b1; cfg_ratio_sel = 3'(sel); cfg_avg = avg; cfg_wide16 = w16;
    cfg_chan = 5'(ch); cfg_irq_en = ie;
    trig = 1'b1; smp_valid = trig_smp; smp_chan = 5'(ch); smp_data = 12'hFFF;
    @(negedge clk);
    trig = 1'b0; smp_valid = 1'b0;
    check(!res_ready, "R2 start clears ready", int'(res_ready), 0);
    if (scramble) begin
      cfg_ratio_sel = 3'((sel + 1) % 4); cfg_avg = ~avg; cfg_wide16 = ~w16;
      cfg_chan = 5'(ch ^ 2);
    end
    for (int i = 0; i < n; i++) begin
      logic [11:0] d = full ? 12'hFFF : 12'((seed * 37 + i * 101) % 4096);
      if (foreign) begin
        smp_valid = 1'b1; smp_chan = 5'(ch ^ 1); smp_data = 12'hFFF;
        @(negedge clk);
      end
      if (i == n - 1) begin
        check(!res_ready, "R3 no result before last sample", int'(res_ready), 0);
        exp_q.push_back({ie, model(sel, avg, w16, sum + int'(d))});
      end
      smp_valid = 1'b1; smp_chan = 5'(ch); smp_data = d;
      sum += int'(d);
      @(negedge clk);
      if (i % 3 == 0) begin
        smp_valid = 1'b0;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
    @(negedge clk);
    check(res_ready, "R8 ready after burst", int'(res_ready), 1);
    check(exp_q.size() == 0, "R3 burst completed", exp_q.size(), 0);
  endtask

  task automatic feed(input int ch, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      smp_valid = 1'b1; smp_chan = 5'(ch); smp_data = 12'(i * 9);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(res_ready == 1'b0 && res_irq == 1'b0, "R8 reset flags", int'(res_ready), 0);
    check(res_data == 16'd0, "R8 reset data", int'(res_data), 0);

    run_burst(0, 1'b0, 1'b0, 3, 1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 R5 R9
    run_burst(1, 1'b1, 1'b0, 7, 1'b1, 2, 1'b0, 1'b1, 1'b0, 1'b0);   // R4 R6
    run_burst(2, 1'b1, 1'b1, 12, 1'b0, 3, 1'b0, 1'b0, 1'b0, 1'b0);  // R7
    run_burst(3, 1'b0, 1'b0, 31, 1'b1, 4, 1'b1, 1'b0, 1'b0, 1'b0);  // R12 full scale
    check(res_data == 16'd65520, "R12 full-scale sum", int'(res_data), 65520);
    run_burst(5, 1'b0, 1'b0, 0, 1'b0, 5, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 unused code
    run_burst(7, 1'b1, 1'b1, 9, 1'b1, 6, 1'b0, 1'b1, 1'b0, 1'b0);   // R3 R7
    run_burst(1, 1'b0, 1'b0, 5, 1'b1, 7, 1'b0, 1'b0, 1'b1, 1'b0);   // R10 scramble
    run_burst(0, 1'b1, 1'b0, 4, 1'b1, 8, 1'b0, 1'b0, 1'b0, 1'b1);   // R2 sample at start

    // R8: hold, then acknowledge
    held = res_data;
    repeat (4) @(negedge clk);
    check(res_ready, "R8 ready holds", int'(res_ready), 1);
    check(res_data == held, "R8 data holds", int'(res_data), int'(held));
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    check(!res_ready, "R8 ack clears ready", int'(res_ready), 0);

    // R1: disabled block ignores start and samples
    cfg_enable = 1'b0; cfg_ratio_sel = 3'd0; cfg_chan = 5'd2;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    feed(2, 8);
    repeat (2) @(negedge clk);
    check(!res_ready, "R1 disabled no result", int'(res_ready), 0);

    // R11: drop enable mid-burst
    cfg_enable = 1'b1; cfg_irq_en = 1'b1;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    feed(2, 2);
    cfg_enable = 1'b0;
    feed(2, 2);
    cfg_enable = 1'b1;
    feed(2, 4);
    repeat (2) @(negedge clk);
    check(!res_ready, "R11 abandoned burst", int'(res_ready), 0);

    run_burst(2, 1'b0, 1'b0, 2, 1'b1, 9, 1'b0, 1'b1, 1'b0, 1'b0);   // recovery
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule